// File: doc/BRIEF.md
# Wait-Step Trigger Qualifier

This block tells a command sequencer when a wait-for-trigger step has been met. It watches two trigger sources. One is an asynchronous external trigger pin. The other is a software trigger bit held in a control register. While the sequencer holds `wait_active_i` high, the block fires a one-cycle `sat_o` pulse as soon as the selected condition is seen. The block also raises `run_delay_o` in that same cycle to say whether the sequencer should run its programmed step delay before it moves on. The timing of the step delay itself belongs to the sequencer.

A 2-bit mode select sets how the external trigger is judged and whether the exit delay runs. Bit 1 picks the detection style: 0 means edge, 1 means level. Bit 0 set to 1 means the delay is skipped. In edge style the block tracks the synchronized pin on every clock, even outside wait steps, so only a rising edge inside a wait counts. In level style a high pin counts only while a wait is active. The software bit has its own edge/level select. In edge style the block pulses `sw_clr_o` so that the register clears the bit it has consumed. In level style the bit stays set until software lowers it.

Top module: `wait_trig_detect`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `sat_o`, `run_delay_o` and `sw_clr_o` are all 0.
- R2: In modes 0 and 1, a low-to-high change on `trig_i` during an active wait passes through a two-flop synchronizer. `sat_o` is then high in the cycle after the third rising clock edge that follows the change.
- R3: In modes 0 and 1, a `trig_i` that is already high when the wait begins does not satisfy the wait. A later rising edge does.
- R4: In modes 2 and 3, a synchronized `trig_i` that is high during an active wait satisfies it, even if the pin went high before the wait began.
- R5: In modes 2 and 3, a high `trig_i` seen while `wait_active_i` is low has no effect, and it leaves nothing pending for a later wait.
- R6: `sat_o` is high for exactly one cycle per wait step. No second pulse follows until `wait_active_i` has gone low and high again.
- R7: `run_delay_o` equals 1 with `sat_o` when `mode_i` bit 0 is 0 (modes 0 and 2). It is 0 in modes 1 and 3, and it is 0 whenever `sat_o` is 0.
- R8: With `sw_edge_i`=1, a set `sw_trig_i` that is sampled during an active wait gives `sat_o` one cycle later. `sw_clr_o` pulses in the same cycle as that `sat_o`.
- R9: With `sw_edge_i`=0, a set `sw_trig_i` during an active wait gives `sat_o` one cycle later. `sw_clr_o` stays 0, so the bit stays set.
- R10: A set `sw_trig_i` while `wait_active_i` is low gives no `sat_o` and no `sw_clr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 1: 0 edge / 1 level; bit 0: 1 skips the exit delay |
| trig_i | input | 1 | External trigger, asynchronous |
| sw_trig_i | input | 1 | Software trigger bit from the control register |
| sw_edge_i | input | 1 | 1: software trigger is edge style (self-clearing); 0: level style |
| wait_active_i | input | 1 | Sequencer is executing a wait-for-trigger step |
| sat_o | output | 1 | One-cycle pulse: the wait is satisfied |
| run_delay_o | output | 1 | Valid with `sat_o`: run the step delay on exit |
| sw_clr_o | output | 1 | One-cycle strobe that clears the software trigger bit |

## Verification
The external pin is driven in three ways. It rises inside a wait. It is already high when a wait opens. It pulses high only while no wait is active. Taken together, these separate edge tracking from level sampling. A pin held high through a long wait shows whether the output is a single pulse or a repeated one. The software bit is set in both of its styles and also outside a wait. This tells apart self-clearing consumption, a bit that stays set, and inputs that are rightly ignored. Each pattern is run in all four modes so the exit-delay flag is seen with both values.

// File: rtl/wtd_pkg.sv
package wtd_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_EDGE_DLY   = 2'd0,
    MODE_EDGE_NODLY = 2'd1,
    MODE_LVL_DLY    = 2'd2,
    MODE_LVL_NODLY  = 2'd3
  } wtd_mode_e;

  function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_runs_delay(input logic [MODE_W-1:0] m);
    return ~m[0];
  endfunction
endpackage

// File: rtl/wtd_sync.sv
module wtd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[i] <= 1'b0;
      end else if (i == 0) begin
        chain_q[i] <= d_i;
      end else begin
        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wtd_rise.sv
module wtd_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  // tracks every cycle, independent of wait steps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/wtd_qual.sv
module wtd_qual
  import wtd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ext_lvl_i,
  input  logic              ext_rise_i,
  input  logic              sw_trig_i,
  input  logic              sw_edge_i,
  input  logic              wait_active_i,
  output logic              sat_o,
  output logic              run_delay_o,
  output logic              sw_clr_o
);
  logic done_q;
  logic armed;
  logic ext_hit;
  logic sw_hit;
  logic hit;

  always_comb begin
    armed   = wait_active_i & ~done_q;
    ext_hit = armed & (mode_is_level(mode_i) ? ext_lvl_i : ext_rise_i);
    sw_hit  = armed & sw_trig_i;
    hit     = ext_hit | sw_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      sat_o       <= 1'b0;
      run_delay_o <= 1'b0;
      sw_clr_o    <= 1'b0;
    end else begin
      sat_o       <= hit;
      run_delay_o <= hit & mode_runs_delay(mode_i);
      sw_clr_o    <= sw_hit & sw_edge_i;
      if (!wait_active_i) done_q <= 1'b0;
      else if (hit)       done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wait_trig_detect.sv
module wait_trig_detect
  import wtd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              trig_i,
  input  logic              sw_trig_i,
  input  logic              sw_edge_i,
  input  logic              wait_active_i,
  output logic              sat_o,
  output logic              run_delay_o,
  output logic              sw_clr_o
);
  logic trig_sync;
  logic trig_rise;

  wtd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (trig_i),
    .q_o    (trig_sync)
  );

  wtd_rise u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (trig_sync),
    .rise_o (trig_rise)
  );

  wtd_qual u_qual (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .ext_lvl_i     (trig_sync),
    .ext_rise_i    (trig_rise),
    .sw_trig_i     (sw_trig_i),
    .sw_edge_i     (sw_edge_i),
    .wait_active_i (wait_active_i),
    .sat_o         (sat_o),
    .run_delay_o   (run_delay_o),
    .sw_clr_o      (sw_clr_o)
  );
endmodule

// File: rtl/wait_trig_detect_chk.sv
module wait_trig_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       sw_trig_i,
  input logic       sw_edge_i,
  input logic       wait_active_i,
  input logic       sat_o,
  input logic       run_delay_o,
  input logic       sw_clr_o
);
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |=> !sat_o);

  p_delay_needs_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sat_o |-> !run_delay_o);

  p_delay_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_delay_o |-> !$past(mode_i[0]));

  p_clr_with_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_o |-> sat_o);

  p_clr_edge_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_o |-> ($past(sw_edge_i) && $past(sw_trig_i)));

  p_sat_in_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> $past(wait_active_i));

  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!sat_o && !run_delay_o && !sw_clr_o);
    end
  end
endmodule

bind wait_trig_detect wait_trig_detect_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .sw_trig_i     (sw_trig_i),
  .sw_edge_i     (sw_edge_i),
  .wait_active_i (wait_active_i),
  .sat_o         (sat_o),
  .run_delay_o   (run_delay_o),
  .sw_clr_o      (sw_clr_o)
);

// File: tb/wait_trig_detect_tb_top.sv
module wait_trig_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       trig = 1'b0;
  logic       sw_bit = 1'b0;
  logic       sw_edge = 1'b0;
  logic       wait_act = 1'b0;
  logic       sat, run_delay, sw_clr;

  int n_checks = 0;
  int n_fail = 0;
  int sat_seen = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  int sq[$];
  int m_prev = 0;
  int m_done = 0;
  int e_sat = 0, e_rd = 0, e_clr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_trig_detect dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mode_i        (mode),
    .trig_i        (trig),
    .sw_trig_i     (sw_bit),
    .sw_edge_i     (sw_edge),
    .wait_active_i (wait_act),
    .sat_o         (sat),
    .run_delay_o   (run_delay),
    .sw_clr_o      (sw_clr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = {0, 0};
      m_prev = 0; m_done = 0;
      e_sat = 0; e_rd = 0; e_clr = 0;
    end else begin
      int s2, ext_hit, sw_hit, armed;
      s2 = sq[0];
      armed = (wait_act && !m_done) ? 1 : 0;
      if (mode[1]) ext_hit = armed && s2;
      else         ext_hit = armed && s2 && !m_prev;
      sw_hit = armed && sw_bit;
      e_sat = (ext_hit || sw_hit) ? 1 : 0;
      e_rd  = (e_sat && !mode[0]) ? 1 : 0;
      e_clr = (sw_hit && sw_edge) ? 1 : 0;
      if (!wait_act) m_done = 0;
      else if (e_sat) m_done = 1;
      m_prev = s2;
      void'(sq.pop_front());
      sq.push_back(int'(trig));
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(cur_req, "sat_o", int'(sat), e_sat);
    chk(cur_req, "run_delay_o", int'(run_delay), e_rd);
    chk(cur_req, "sw_clr_o", int'(sw_clr), e_clr);
    if (sat) sat_seen++;
    if (sw_clr) sw_bit = 1'b0;  // register reacts to the clear strobe
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle_gap();
    wait_act = 1'b0; trig = 1'b0; sw_bit = 1'b0;
    steps(5);
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYCLES);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    steps(3);
    chk("R1", "reset sat_o", int'(sat), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "post-reset sat_o", int'(sat), 0);
    steps(3);

    // R2/R7: rising edge inside a wait, all edge modes
    for (int m = 0; m < 2; m++) begin
      cur_req = (m == 0) ? "R2" : "R7";
      mode = 2'(m); wait_act = 1'b1;
      steps(2);
      trig = 1'b1;
      steps(2);
      chk("R2", "no early sat", int'(sat), 0);
      step();
      chk("R2", "sat on third edge", int'(sat), 1);
      chk("R7", "delay flag", int'(run_delay), (m == 0) ? 1 : 0);
      steps(3);
      idle_gap();
    end

    // R3: pin already high when the wait opens
    cur_req = "R3";
    mode = 2'd0; trig = 1'b1;
    steps(5);
    sat_seen = 0;
    wait_act = 1'b1;
    steps(6);
    chk("R3", "no sat for stale high", sat_seen, 0);
    trig = 1'b0; steps(4);
    trig = 1'b1; steps(5);
    chk("R3", "later edge satisfies", sat_seen, 1);
    idle_gap();

    // R4/R7: level modes with pin high before the wait
    for (int m = 2; m < 4; m++) begin
      cur_req = (m == 2) ? "R4" : "R7";
      mode = 2'(m); trig = 1'b1;
      steps(4);
      sat_seen = 0;
      wait_act = 1'b1;
      step();
      chk("R4", "level sat", int'(sat), 1);
      chk("R7", "level delay flag", int'(run_delay), (m == 2) ? 1 : 0);
      steps(4);
      idle_gap();
    end

    // R5: level pulse outside any wait leaves nothing pending
    cur_req = "R5";
    mode = 2'd2;
    trig = 1'b1; steps(4);
    trig = 1'b0; steps(4);
    sat_seen = 0;
    wait_act = 1'b1; steps(6);
    chk("R5", "no sat from earlier pulse", sat_seen, 0);
    idle_gap();

    // R6: held high through long wait, then a second wait
    cur_req = "R6";
    mode = 2'd3; trig = 1'b1; steps(3);
    sat_seen = 0;
    wait_act = 1'b1; steps(10);
    chk("R6", "one pulse per wait", sat_seen, 1);
    wait_act = 1'b0; step();
    wait_act = 1'b1; steps(4);
    chk("R6", "re-armed after wait drop", sat_seen, 2);
    idle_gap();

    // R8: software edge style, self-clearing
    cur_req = "R8";
    mode = 2'd1; sw_edge = 1'b1; wait_act = 1'b1; steps(2);
    sat_seen = 0;
    sw_bit = 1'b1;
    step();
    chk("R8", "sw edge sat", int'(sat), 1);
    chk("R8", "sw clear strobe", int'(sw_clr), 1);
    steps(3);
    chk("R8", "sw bit consumed", int'(sw_bit), 0);
    chk("R8", "single sat", sat_seen, 1);
    idle_gap();

    // R9: software level style, bit persists
    cur_req = "R9";
    mode = 2'd0; sw_edge = 1'b0; wait_act = 1'b1; steps(2);
    sw_bit = 1'b1;
    step();
    chk("R9", "sw level sat", int'(sat), 1);
    chk("R9", "no clear strobe", int'(sw_clr), 0);
    steps(4);
    chk("R9", "sw bit still set", int'(sw_bit), 1);
    idle_gap();

    // R10: software bit set outside a wait, both styles
    cur_req = "R10";
    for (int e = 0; e < 2; e++) begin
      sw_edge = 1'(e);
      sat_seen = 0;
      sw_bit = 1'b1; steps(6);
      chk("R10", "no sat outside wait", sat_seen, 0);
      chk("R10", "bit untouched outside wait", int'(sw_bit), 1);
      idle_gap();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule